// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block collects a parameterised set of external interrupt lines and presents the most urgent one to a single processor through one interrupt output. Each source has a configuration word and a routing word, both reached through a simple register bus. The configuration word sets the source's priority, the vector it reports, and how its input is sampled: on an edge or on a level, with either polarity. The same word also carries a mask, and a read-only activity flag that software polls before it reprograms the source.

The processor side has four parts. A task-priority threshold sets which sources may interrupt at all. An acknowledge register returns the vector of the winning source and moves that source into service. If no source qualifies, the acknowledge register returns a programmable spurious vector instead. A write to the end-of-interrupt register retires the most urgent source in service. Sources in service can nest, so a source interrupts only when its priority is above every source already in service. A self-clearing reset bit returns the whole controller to its initial state. A read-only feature word reports the size of the controller.

Top module: `vpic`

## Requirements
- R1: After reset, each source config word reads 0x80020000 with an inactive input: bit 31 mask is 1, bit 17 sense is 1 (level), bit 16 polarity is 0 (active low), bits 11:8 priority are 0, and bits 7:0 vector are 0. Every routing word reads 0, task priority (address 3) reads 15, spurious vector (address 2) reads 0xFF, and irq_out is 0.
- R2: The feature word at address 1 holds the version in bits 7:0, the last processor index (0) in bits 15:8, and the last source index (NSRC-1) in bits 26:16.
- R3: A masked source never drives irq_out and is never returned by acknowledge. It still latches pending state, which shows in its activity flag.
- R4: Bit 30 of a config word reads 1 while its source is pending or in service, and 0 otherwise.
- R5: With sense 0, a source becomes pending on an input edge in the direction set by polarity: rising when polarity is 1, falling when it is 0. The opposite edge has no effect. With sense 1, the input level selected by polarity is pending while it is held.
- R6: Among qualifying sources, the one with the highest priority wins, and a tie goes to the lowest source index. A source with priority 0 is never delivered.
- R7: A source is delivered only if its priority is strictly greater than the task priority, so a task priority of 15 blocks every source.
- R8: A read of address 4 returns the winner's vector in bits 7:0 and puts the winner in service. When nothing qualifies, the read returns the programmed spurious vector.
- R9: While sources are in service, only a source of strictly higher priority than all of them is delivered. Any write to address 5 retires the highest-priority source in service.
- R10: A source is delivered only when bit 0 of its routing word (address 17+2i) is set. The config word of source i is at address 16+2i.
- R11: Writing 1 to bit 0 of address 0 makes that bit read 1 for one cycle. The controller then returns to the R1 state and the bit reads 0.
- R12: Acknowledging an edge source clears its pending latch, and it does not fire again until a new edge. A level source held active is not delivered again until its end-of-interrupt, after which it is re-sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | NSRC | External interrupt lines |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from address |
| irq_out | output | 1 | Interrupt request to the processor |

## Verification
The threshold is swept over every pair of source priority and task priority, using one held level source. This separates the strict-greater comparison from an off-by-one. Arbitration is swept over every priority pair of two edge sources that fire together. This tells the highest-priority choice apart from the lowest-index tie break, and shows that priority-0 sources resolve to the spurious vector. Directed sequences cover the remaining behaviour. Edge and level sources are contrasted after acknowledge and after end-of-interrupt. Nested service shows which source an end-of-interrupt retires. Mask, routing and the self-clearing reset are each checked through the registers and irq_out.

// File: rtl/vpic.sv
module vpic #(
  parameter int NSRC = 4,
  parameter logic [7:0] VERSION = 8'h02
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] irq_in,
  input  logic            bus_sel,
  input  logic            bus_we,
  input  logic [7:0]      bus_addr,
  input  logic [31:0]     bus_wdata,
  output logic [31:0]     bus_rdata,
  output logic            irq_out
);
  localparam int IW = (NSRC > 1) ? $clog2(NSRC) : 1;

  logic [NSRC-1:0] mask, sense, pol, dest, edge_q, in_q, insvc;
  logic [3:0]      pri [NSRC];
  logic [7:0]      vec [NSRC];
  logic [3:0]      tpri;
  logic [7:0]      spur;
  logic            soft_rst;

  logic [NSRC-1:0] edge_ev, lvl_act, pend, qual;
  logic [IW-1:0]   win, eidx;
  logic [3:0]      wpri, ipri;
  logic            found;

  assign edge_ev = (pol & irq_in & ~in_q) | (~pol & ~irq_in & in_q);
  assign lvl_act = ~(irq_in ^ pol);
  assign pend    = (sense & lvl_act & ~insvc) | (~sense & edge_q);

  always_comb begin
    ipri = '0;
    eidx = '0;
    for (int i = NSRC - 1; i >= 0; i--)
      if (insvc[i] && pri[i] >= ipri) begin
        ipri = pri[i];
        eidx = IW'(i);
      end
  end

  always_comb begin
    wpri  = '0;
    win   = '0;
    found = 1'b0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      qual[i] = ~mask[i] & pend[i] & dest[i] & (pri[i] > tpri) & (pri[i] > ipri);
      if (qual[i] && pri[i] >= wpri) begin
        wpri  = pri[i];
        win   = IW'(i);
        found = 1'b1;
      end
    end
  end

  assign irq_out = found;

  logic [7:0]    soff;
  logic          sel_src;
  logic [IW-1:0] sidx;
  logic          wr, ack_rd, eoi_wr;

  assign soff    = bus_addr - 8'd16;
  assign sel_src = (bus_addr >= 8'd16) && ({1'b0, soff} < 9'(2 * NSRC));
  assign sidx    = soff[IW:1];
  assign wr      = bus_sel & bus_we;
  assign ack_rd  = bus_sel & ~bus_we & (bus_addr == 8'd4);
  assign eoi_wr  = wr & (bus_addr == 8'd5);

  always_comb begin
    bus_rdata = '0;
    if (sel_src) begin
      if (soff[0]) bus_rdata = {31'b0, dest[sidx]};
      else bus_rdata = {mask[sidx], pend[sidx] | insvc[sidx], 12'b0, sense[sidx],
                        pol[sidx], 4'b0, pri[sidx], vec[sidx]};
    end else begin
      case (bus_addr)
        8'd0: bus_rdata = {31'b0, soft_rst};
        8'd1: bus_rdata = {5'b0, 11'(NSRC - 1), 8'd0, VERSION};
        8'd2: bus_rdata = {24'b0, spur};
        8'd3: bus_rdata = {28'b0, tpri};
        8'd4: bus_rdata = {24'b0, found ? vec[win] : spur};
        default: bus_rdata = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_q     <= '0;
      soft_rst <= 1'b0;
      tpri     <= 4'hF;
      spur     <= 8'hFF;
      mask     <= '1;
      sense    <= '1;
      pol      <= '0;
      dest     <= '0;
      edge_q   <= '0;
      insvc    <= '0;
      for (int i = 0; i < NSRC; i++) begin
        pri[i] <= '0;
        vec[i] <= '0;
      end
    end else begin
      in_q <= irq_in;
      if (soft_rst) begin
        soft_rst <= 1'b0;
        tpri     <= 4'hF;
        spur     <= 8'hFF;
        mask     <= '1;
        sense    <= '1;
        pol      <= '0;
        dest     <= '0;
        edge_q   <= '0;
        insvc    <= '0;
        for (int i = 0; i < NSRC; i++) begin
          pri[i] <= '0;
          vec[i] <= '0;
        end
      end else begin
        edge_q <= edge_q | (edge_ev & ~sense);
        if (ack_rd && found) begin
          insvc[win]  <= 1'b1;
          edge_q[win] <= 1'b0;
        end
        if (eoi_wr && |insvc) insvc[eidx] <= 1'b0;
        if (wr && sel_src) begin
          if (soff[0]) dest[sidx] <= bus_wdata[0];
          else begin
            mask[sidx]  <= bus_wdata[31];
            sense[sidx] <= bus_wdata[17];
            pol[sidx]   <= bus_wdata[16];
            pri[sidx]   <= bus_wdata[11:8];
            vec[sidx]   <= bus_wdata[7:0];
          end
        end
        if (wr && bus_addr == 8'd0 && bus_wdata[0]) soft_rst <= 1'b1;
        if (wr && bus_addr == 8'd2) spur <= bus_wdata[7:0];
        if (wr && bus_addr == 8'd3) tpri <= bus_wdata[3:0];
      end
    end
  end
endmodule

// File: rtl/vpic_chk.sv
module vpic_chk #(
  parameter int NSRC = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            bus_sel,
  input logic            bus_we,
  input logic [7:0]      bus_addr,
  input logic [31:0]     bus_rdata,
  input logic            irq_out,
  input logic [3:0]      tpri,
  input logic [7:0]      spur,
  input logic [NSRC-1:0] insvc,
  input logic [NSRC-1:0] mask,
  input logic            soft_rst
);
  logic ack_rd, eoi_wr;
  assign ack_rd = bus_sel && !bus_we && bus_addr == 8'd4;
  assign eoi_wr = bus_sel && bus_we && bus_addr == 8'd5;

  AST_TPRI_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    tpri == 4'hF |-> !irq_out); // R7
  AST_MASK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    mask == '1 |-> !irq_out); // R3
  AST_SPURIOUS_VEC: assert property (@(posedge clk) disable iff (!rst_n)
    ack_rd && !irq_out |-> bus_rdata[7:0] == spur); // R8
  AST_ACK_ENTERS: assert property (@(posedge clk) disable iff (!rst_n)
    ack_rd && irq_out && !soft_rst |=> $countones(insvc) == $countones($past(insvc)) + 1); // R8
  AST_EOI_RETIRES: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_wr && insvc != '0 && !soft_rst |=> $countones(insvc) == $countones($past(insvc)) - 1); // R9
  AST_SOFT_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> !soft_rst && tpri == 4'hF && mask == '1 && insvc == '0); // R11
endmodule

bind vpic vpic_chk #(.NSRC(NSRC)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_rdata(bus_rdata), .irq_out(irq_out),
  .tpri(tpri), .spur(spur), .insvc(insvc), .mask(mask), .soft_rst(soft_rst)
);

// File: tb/test_vpic.sv
module test_vpic;
  localparam int NSRC = 4;
  logic clk = 0, rst_n = 0;
  logic [NSRC-1:0] irq_in = '1;
  logic bus_sel = 0, bus_we = 0;
  logic [7:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic irq_out;
  int checks = 0, errors = 0;

  vpic #(.NSRC(NSRC)) i_vpic (.clk(clk), .rst_n(rst_n), .irq_in(irq_in),
    .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out));

  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1 bus_sel = 0; bus_we = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_we = 0; bus_addr = a;
    #1 d = bus_rdata;
    @(posedge clk); #1 bus_sel = 0;
  endtask

  function automatic logic [31:0] vp(input logic m, input logic s, input logic p,
                                     input logic [3:0] pr, input logic [7:0] v);
    return {m, 1'b0, 12'b0, s, p, 4'b0, pr, v};
  endfunction

  task automatic setin(input int i, input logic v);
    @(negedge clk); irq_in[i] = v; @(posedge clk); #1;
  endtask

  task automatic pulse2;
    @(negedge clk); irq_in[1] = 1; irq_in[2] = 1;
    @(negedge clk); irq_in[1] = 0; irq_in[2] = 0;
    @(posedge clk); #1;
  endtask

  initial begin
    #1_000_000;
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [7:0] ev;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    for (int i = 0; i < NSRC; i++) begin
      rd(8'(16 + 2 * i), d); chk("R1 config reset", d, 32'h8002_0000);
      rd(8'(17 + 2 * i), d); chk("R1 route reset", d, 0);
    end
    rd(3, d); chk("R1 task priority", d, 15);
    rd(2, d); chk("R1 spurious", d, 32'hFF);
    chk("R1 irq_out", irq_out, 0);
    rd(1, d); chk("R2 feature", d, ((NSRC - 1) << 16) | 32'h02);

    // R7 threshold sweep with source 0 level, active high, input held high
    irq_in = 4'b1111;
    wr(17, 1);
    for (int p = 0; p < 16; p++)
      for (int t = 0; t < 16; t++) begin
        wr(16, vp(0, 1, 1, 4'(p), 8'h40));
        wr(3, 32'(t));
        chk("R7 threshold", irq_out, 32'(p > t));
      end

    wr(3, 0);
    wr(16, vp(1, 1, 1, 5, 8'h40));
    chk("R3 masked no irq", irq_out, 0);
    rd(4, d); chk("R3 masked ack spurious", d, 32'hFF);
    rd(16, d); chk("R4 activity while masked", d[30], 1);
    wr(16, vp(0, 1, 1, 5, 8'h40));
    wr(17, 0);
    chk("R10 route bit clear", irq_out, 0);
    wr(17, 1);
    chk("R10 route bit set", irq_out, 1);
    rd(4, d); chk("R8 ack vector", d, 32'h40);
    chk("R12 level held in service", irq_out, 0);
    rd(16, d); chk("R4 activity in service", d[30], 1);
    wr(5, 0);
    chk("R12 level re-sampled after EOI", irq_out, 1);
    setin(0, 0);
    chk("R5 level inactive", irq_out, 0);
    rd(16, d); chk("R4 activity idle", d[30], 0);
    wr(16, vp(1, 1, 1, 5, 8'h40));

    // R6/R8 arbitration sweep, sources 1 and 2 edge rising
    wr(2, 32'hA5);
    irq_in[2:1] = 2'b00;
    wr(19, 1); wr(21, 1);
    for (int pa = 0; pa < 16; pa++)
      for (int pb = 0; pb < 16; pb++) begin
        wr(18, vp(0, 0, 1, 4'(pa), 8'h11));
        wr(20, vp(0, 0, 1, 4'(pb), 8'h22));
        pulse2();
        if (pa == 0 && pb == 0) ev = 8'hA5;
        else if (pa >= pb) ev = 8'h11;
        else ev = 8'h22;
        rd(4, d); chk("R6 first winner", d, {24'b0, ev});
        wr(5, 0);
        if (ev == 8'h11) ev = (pb > 0) ? 8'h22 : 8'hA5;
        else if (ev == 8'h22) ev = (pa > 0) ? 8'h11 : 8'hA5;
        rd(4, d); chk("R6 second winner", d, {24'b0, ev});
        wr(5, 0);
      end

    // R5/R12 falling-edge source 3
    wr(23, 1);
    wr(22, vp(0, 0, 0, 3, 8'h33));
    chk("R5 no edge yet", irq_out, 0);
    setin(3, 0);
    chk("R5 falling edge pends", irq_out, 1);
    rd(4, d); chk("R8 edge vector", d, 32'h33);
    chk("R12 edge latch cleared", irq_out, 0);
    wr(5, 0);
    chk("R12 edge not re-sampled", irq_out, 0);
    rd(22, d); chk("R4 activity edge idle", d[30], 0);
    setin(3, 1);
    chk("R5 opposite edge ignored", irq_out, 0);

    // R9 nesting
    wr(18, vp(0, 0, 1, 4, 8'h11));
    wr(20, vp(0, 0, 1, 9, 8'h22));
    setin(1, 1); setin(1, 0);
    rd(4, d); chk("R9 low enters", d, 32'h11);
    setin(2, 1); setin(2, 0);
    chk("R9 higher preempts", irq_out, 1);
    rd(4, d); chk("R9 higher vector", d, 32'h22);
    setin(1, 1); setin(1, 0);
    chk("R9 lower blocked", irq_out, 0);
    wr(5, 0);
    chk("R9 EOI retired higher only", irq_out, 0);
    wr(5, 0);
    chk("R9 EOI retired lower", irq_out, 1);
    rd(4, d); chk("R9 redelivered", d, 32'h11);
    wr(5, 0);

    // R11 soft reset
    irq_in = '1;
    wr(3, 2);
    wr(0, 1);
    rd(0, d); chk("R11 bit reads busy", d, 1);
    rd(0, d); chk("R11 bit self-clears", d, 0);
    rd(18, d); chk("R11 config restored", d, 32'h8002_0000);
    rd(19, d); chk("R11 route restored", d, 0);
    rd(3, d); chk("R11 task priority restored", d, 15);
    rd(2, d); chk("R11 spurious restored", d, 32'hFF);
    chk("R11 irq_out", irq_out, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule